// File: doc/BRIEF.md
# Windowed Display RAM Address Counter

This block is the address generator that a display controller uses to place pixel data in its frame memory. The panel is 128 columns by 160 rows. The memory address is the row number in the upper byte and the column number in the lower byte. Software programs the block through a small register port. It can load the counter directly, restrict the writable area to a rectangle, choose how the counter moves, and protect chosen data bits from change.

On every pixel write strobe the block presents the current address together with a per-bit write enable. In the following cycle the counter moves one step inside the programmed rectangle. The entry mode sets the stepping. Each axis can count up or down, and either the column or the row can be the axis that moves first. When the first-moving axis leaves its range, it reloads at the opposite edge of the rectangle and the other axis takes one step. Pixel reads present the address but do not move the counter.

Top module: `disp_addr_gen`

## Requirements
- R1: After reset the address is 0. The column range is 0..127 and the row range is 0..159. Both axes count up, the column moves first, and the protect mask is 0, so a pixel write enables all 16 bits.
- R2: A register write with select 0 loads the counter: data bits [15:8] become the row and bits [7:0] become the column. The new address appears on `px_addr` (row in [15:8], column in [7:0]) in the cycle after the write.
- R3: Select 1 loads the column range and select 2 loads the row range, each with the end in bits [15:8] and the start in bits [7:0]. Loading a range does not move the counter.
- R4: Select 3 loads the entry mode. Bit 0 = 1 makes the column count up and 0 makes it count down. Bit 1 does the same for the row. Bit 2 = 1 makes the row the axis that moves first, and 0 makes the column move first.
- R5: A pixel write moves the first-moving axis one step in its direction on the next clock, and the other axis stays unchanged, as long as the first-moving axis is not at its far edge.
- R6: A pixel write with the first-moving axis at its far edge (the end when counting up, the start when counting down) reloads that axis at the opposite edge and moves the other axis one step.
- R7: When both axes are at their far edges, a pixel write returns the address to the starting corner of the rectangle that the entry mode implies.
- R8: Select 4 loads the protect mask. While `px_wr` is high, `px_bit_we` is the inverse of the mask; otherwise it is all zeros.
- R9: A pixel read (`px_rd`) without a pixel write leaves the address unchanged.
- R10: When a counter load and a pixel write occur in the same cycle, the load wins. A range, mode or mask write in the same cycle as a pixel write takes effect only from the next cycle; the current step and enables use the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 counter, 1 column range, 2 row range, 3 mode, 4 mask |
| reg_wdata | input | 16 | Register write data |
| px_wr | input | 1 | Pixel write strobe, advances the counter |
| px_rd | input | 1 | Pixel read strobe, no advance |
| px_addr | output | 16 | Current memory address, row high byte, column low byte |
| px_bit_we | output | 16 | Per-bit write enable for the current pixel write |

## Verification
Two functions can fall in the same cycle: a register write and a pixel-write advance. The bench provokes this directly. It issues a counter load together with a pixel write, and it also changes the range, the mode and the mask in the same cycle as a pixel write. A behavioural model applies the load-over-step priority and the rule that new settings take effect on the next cycle. The model is compared with both outputs on every clock. The wrap cases are checked in all four direction combinations, with both orders of axis movement, and also at the edges of the full panel.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
    localparam int AXW = 8;
    localparam int DW  = 16;

    localparam logic [2:0] SEL_ADDR = 3'd0;
    localparam logic [2:0] SEL_HWIN = 3'd1;
    localparam logic [2:0] SEL_VWIN = 3'd2;
    localparam logic [2:0] SEL_MODE = 3'd3;
    localparam logic [2:0] SEL_MASK = 3'd4;

    typedef struct packed {
        logic           col_up;
        logic           row_up;
        logic           row_first;
    } mode_t;

    typedef struct packed {
        logic [AXW-1:0] col;
        logic [AXW-1:0] row;
        logic [AXW-1:0] h_lo;
        logic [AXW-1:0] h_hi;
        logic [AXW-1:0] v_lo;
        logic [AXW-1:0] v_hi;
        mode_t          mode;
        logic [DW-1:0]  mask;
    } state_t;
endpackage

// File: rtl/ax_step.sv
module ax_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         up,
    input  logic         step,
    output logic         at_edge,
    output logic [W-1:0] nxt
);
    always_comb begin
        at_edge = up ? (cur == hi) : (cur == lo);
        nxt     = cur;
        if (step) begin
            if (at_edge)
                nxt = up ? lo : hi;
            else
                nxt = up ? cur + W'(1) : cur - W'(1);
        end
    end
endmodule

// File: rtl/wmask_gen.sv
module wmask_gen #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] mask,
    input  logic          wr,
    output logic [DW-1:0] bit_we
);
    always_comb begin
        bit_we = wr ? ~mask : '0;
    end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
    import disp_addr_pkg::*;
#(
    parameter int COLS = 128,
    parameter int ROWS = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_sel,
    input  logic [DW-1:0]        reg_wdata,
    input  logic                 px_wr,
    input  logic                 px_rd,
    output logic [2*AXW-1:0]     px_addr,
    output logic [DW-1:0]        px_bit_we
);
    localparam int AW = 2 * AXW;
    localparam logic [AXW-1:0] COL_LAST = AXW'(COLS - 1);
    localparam logic [AXW-1:0] ROW_LAST = AXW'(ROWS - 1);

    state_t st_q, st_d;

    logic           h_edge, v_edge;
    logic           h_step, v_step;
    logic [AXW-1:0] h_nxt, v_nxt;
    logic           load_addr;

    assign load_addr = reg_we && (reg_sel == SEL_ADDR);

    always_comb begin
        if (st_q.mode.row_first) begin
            v_step = px_wr;
            h_step = px_wr && v_edge;
        end else begin
            h_step = px_wr;
            v_step = px_wr && h_edge;
        end
    end

    ax_step #(.W(AXW)) u_col (
        .cur     (st_q.col),
        .lo      (st_q.h_lo),
        .hi      (st_q.h_hi),
        .up      (st_q.mode.col_up),
        .step    (h_step),
        .at_edge (h_edge),
        .nxt     (h_nxt)
    );

    ax_step #(.W(AXW)) u_row (
        .cur     (st_q.row),
        .lo      (st_q.v_lo),
        .hi      (st_q.v_hi),
        .up      (st_q.mode.row_up),
        .step    (v_step),
        .at_edge (v_edge),
        .nxt     (v_nxt)
    );

    wmask_gen #(.DW(DW)) u_mask (
        .mask   (st_q.mask),
        .wr     (px_wr),
        .bit_we (px_bit_we)
    );

    always_comb begin
        st_d     = st_q;
        st_d.col = h_nxt;
        st_d.row = v_nxt;
        if (reg_we) begin
            unique case (reg_sel)
                SEL_ADDR: begin
                    st_d.row = reg_wdata[AW-1:AXW];
                    st_d.col = reg_wdata[AXW-1:0];
                end
                SEL_HWIN: begin
                    st_d.h_hi = reg_wdata[AW-1:AXW];
                    st_d.h_lo = reg_wdata[AXW-1:0];
                end
                SEL_VWIN: begin
                    st_d.v_hi = reg_wdata[AW-1:AXW];
                    st_d.v_lo = reg_wdata[AXW-1:0];
                end
                SEL_MODE: begin
                    st_d.mode.col_up    = reg_wdata[0];
                    st_d.mode.row_up    = reg_wdata[1];
                    st_d.mode.row_first = reg_wdata[2];
                end
                SEL_MASK: st_d.mask = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.col  <= '0;
            st_q.row  <= '0;
            st_q.h_lo <= '0;
            st_q.h_hi <= COL_LAST;
            st_q.v_lo <= '0;
            st_q.v_hi <= ROW_LAST;
            st_q.mode <= '{col_up: 1'b1, row_up: 1'b1, row_first: 1'b0};
            st_q.mask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign px_addr = {st_q.row, st_q.col};

endmodule

// File: rtl/disp_addr_gen_chk.sv
module disp_addr_gen_chk
    import disp_addr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [2:0]           reg_sel,
    input logic [DW-1:0]        reg_wdata,
    input logic                 px_wr,
    input logic                 px_rd,
    input logic [2*AXW-1:0]     px_addr,
    input logic [DW-1:0]        px_bit_we,
    input state_t               st_q
);
    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_ADDR) |=> (px_addr == $past(reg_wdata)));

    // R3
    win_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_sel == SEL_HWIN || reg_sel == SEL_VWIN) && !px_wr) |=> $stable(px_addr));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_rd && !px_wr && !reg_we) |=> $stable(px_addr));

    // R8
    idle_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_wr |-> (px_bit_we == '0));

    // R5
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_wr && !reg_we && !st_q.mode.row_first && st_q.mode.col_up
         && st_q.col != st_q.h_hi)
        |=> (px_addr[AXW-1:0] == $past(px_addr[AXW-1:0]) + AXW'(1))
            && (px_addr[2*AXW-1:AXW] == $past(px_addr[2*AXW-1:AXW])));
endmodule

bind disp_addr_gen disp_addr_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .px_wr     (px_wr),
    .px_rd     (px_rd),
    .px_addr   (px_addr),
    .px_bit_we (px_bit_we),
    .st_q      (st_q)
);

// File: tb/disp_addr_gen_test.sv
`timescale 1ns/100ps
module disp_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        px_wr = 1'b0;
    logic        px_rd = 1'b0;
    logic [15:0] px_addr;
    logic [15:0] px_bit_we;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_col, m_row, m_hs, m_he, m_vs, m_ve, m_cup, m_rup, m_rfirst;
    int m_mask;

    always #2.5 clk = ~clk;

    disp_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .px_wr(px_wr), .px_rd(px_rd),
        .px_addr(px_addr), .px_bit_we(px_bit_we)
    );

    function automatic void model_reset();
        m_col = 0; m_row = 0; m_hs = 0; m_he = 127; m_vs = 0; m_ve = 159;
        m_cup = 1; m_rup = 1; m_rfirst = 0; m_mask = 0;
    endfunction

    // move one axis value; returns 1 when it wrapped
    function automatic int move(inout int v, input int lo, input int hi, input int up);
        if (up != 0) begin
            if (v == hi) begin v = lo; return 1; end
            v = (v + 1) % 256; return 0;
        end
        if (v == lo) begin v = hi; return 1; end
        v = (v + 255) % 256; return 0;
    endfunction

    task automatic compare(input string tag);
        int exp_addr, exp_we;
        exp_addr = m_row * 256 + m_col;
        exp_we   = px_wr ? (~m_mask & 16'hFFFF) : 0;
        n_cmp++;
        if (px_addr !== exp_addr[15:0] || px_bit_we !== exp_we[15:0]) begin
            n_bad++;
            $display("FAIL %s: addr=%h we=%h expected addr=%h we=%h",
                     tag, px_addr, px_bit_we, exp_addr[15:0], exp_we[15:0]);
        end
    endtask

    task automatic cyc(input string tag, input bit we, input int sel, input int data,
                       input bit wr, input bit rd);
        int w;
        reg_we = we; reg_sel = 3'(sel); reg_wdata = 16'(data); px_wr = wr; px_rd = rd;
        #1;
        compare(tag);
        @(posedge clk);
        if (wr && !(we && sel == 0)) begin
            if (m_rfirst != 0) begin
                w = move(m_row, m_vs, m_ve, m_rup);
                if (w != 0) void'(move(m_col, m_hs, m_he, m_cup));
            end else begin
                w = move(m_col, m_hs, m_he, m_cup);
                if (w != 0) void'(move(m_row, m_vs, m_ve, m_rup));
            end
        end
        if (we) begin
            case (sel)
                0: begin m_row = (data >> 8) & 255; m_col = data & 255; end
                1: begin m_he = (data >> 8) & 255; m_hs = data & 255; end
                2: begin m_ve = (data >> 8) & 255; m_vs = data & 255; end
                3: begin m_cup = data & 1; m_rup = (data >> 1) & 1; m_rfirst = (data >> 2) & 1; end
                4: m_mask = data & 16'hFFFF;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic setreg(input string tag, input int sel, input int data);
        cyc(tag, 1'b1, sel, data, 1'b0, 1'b0);
    endtask

    task automatic writes(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, 0, 0, 1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        #12;
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, all bits enabled on write
        cyc("R1", 1'b0, 0, 0, 1'b0, 1'b0);
        writes("R1", 3);
        // R2 load counter near full-panel column end; R6 wrap at 127
        setreg("R2", 0, 16'h037E);
        writes("R6", 3);
        // R3 small rectangle, counter unchanged by range writes
        setreg("R3", 1, 16'h0C0A);
        setreg("R3", 2, 16'h0705);
        cyc("R3", 1'b0, 0, 0, 1'b0, 1'b0);
        setreg("R2", 0, 16'h050A);
        // R5 R6 R7 column first upward, full traversal twice
        writes("R7", 20);
        // R4 row first, both down
        setreg("R4", 3, 3'b100);
        setreg("R2", 0, 16'h070C);
        writes("R7", 11);
        // R4 column down row up, column first
        setreg("R4", 3, 3'b010);
        writes("R6", 10);
        // R4 column up row down, row first
        setreg("R4", 3, 3'b101);
        writes("R5", 10);
        // R8 mask
        setreg("R8", 4, 16'hF0F0);
        writes("R8", 2);
        setreg("R8", 4, 16'hFFFF);
        writes("R8", 1);
        // R9 reads do not advance
        for (int i = 0; i < 4; i++) cyc("R9", 1'b0, 0, 0, 1'b0, 1'b1);
        cyc("R9", 1'b0, 0, 0, 1'b1, 1'b1);
        // R10 same-cycle collisions
        cyc("R10", 1'b1, 0, 16'h0609, 1'b1, 1'b0);
        cyc("R10", 1'b1, 4, 16'h00FF, 1'b1, 1'b0);
        cyc("R10", 1'b1, 3, 3'b011, 1'b1, 1'b0);
        cyc("R10", 1'b1, 1, 16'h0B08, 1'b1, 1'b0);
        cyc("R10", 1'b1, 2, 16'h0906, 1'b1, 1'b0);
        writes("R10", 12);
        // R6 full-panel row wrap at 159
        setreg("R3", 1, 16'h7F00);
        setreg("R3", 2, 16'h9F00);
        setreg("R4", 3, 3'b111);
        setreg("R2", 0, 16'h9E7F);
        writes("R7", 3);
        cyc("R1", 1'b0, 0, 0, 1'b0, 1'b0);
        finish_run();
    end
endmodule